// File: doc/BRIEF.md
# Modulo fractional clock divider

The divider turns a free-running input clock into an enable stream whose average rate is n/m of the input rate, with n no larger than m. The ratio is not held as an integer divisor. Software writes one control word that holds two modulo values. The addition value is m−n. The subtraction value is −n in two's complement of the field width. A signed accumulator walks between them every input cycle.

Each cycle the accumulator tests whether subtracting n would leave it non-negative. If so it subtracts n and no pulse appears. If not it adds m−n and the cycle emits a one-cycle pulse. The accumulator therefore stays in the range from 0 to m−1 and returns to zero every m cycles, and every window of m active cycles holds exactly n pulses. A stretch option widens each pulse until the accumulator falls below half of m, which gives an output clock with a near-even duty cycle. The effective n and m, with common trailing zeros removed, are available as read-back. A parameter picks 8-bit or 13-bit modulo fields.

Top module: `modfrac_clkdiv`

## Requirements
- R1: Control word bits: bit 0 is run, bit 1 is clear, bit 2 is stretch. The addition field starts at bit 3 and the subtraction field starts at bit 3+FW. FW is 8 by default and 13 when WIDE is set, so the word is 3+2·FW bits wide. A write with wr_en high loads the whole word at the clock edge.
- R2: With n = −sub (field-width two's complement) and m = add + n, every run of m consecutive active cycles carries exactly n single-cycle pulses on tick_o. The accumulator never goes negative.
- R3: Shifting both fields left by the same amount gives the same pulse sequence as the unshifted pair.
- R4: A subtraction field of zero, which includes the case where both fields are zero, yields no pulses, and both read-back values are 0.
- R5: An addition field of zero with a non-zero subtraction field gives n = m, and tick_o is high on every active cycle.
- R6: While run is low the accumulator holds and tick_o stays low. When run returns, the pulse count across the interrupted stream still matches R2.
- R7: While clear is set the accumulator is zero and tick_o and div_o stay low. At the first edge after clear is written low, the accumulator is zero, so tick_o is high after that edge.
- R8: With stretch low, div_o equals tick_o on every cycle.
- R9: With stretch high and 2n ≤ m, div_o rises exactly n times in every m cycles and is high on every cycle where tick_o is high.
- R10: n_rb_o and m_rb_o give n and m with the trailing zeros common to both fields removed.
- R11: After reset the control word is zero and every output is 0.
- R12: The 13-bit variant follows R2, R3 and R10 with its wider fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Loads wr_data into the control word |
| wr_data | input | CW (3+2·FW) | New control word |
| tick_o | output | 1 | One-cycle enable pulse, rate n/m |
| div_o | output | 1 | Stretched output when stretch is set, otherwise tick_o |
| n_rb_o | output | FW | Effective n after removing common trailing zeros |
| m_rb_o | output | FW+1 | Effective m after removing common trailing zeros |

## Verification
The hardest case to reach is an accumulator that is frozen mid-stream by a run-low write and then resumed. This only shows up as a correct pulse count across the gap. The bench starts from a cleared accumulator and runs a few active cycles. It then drops run for several cycles, restores it, and counts pulses only over the cycles that were actually active. The write edges are counted with care, because each write edge still takes a decision under the previous word. Random ratios with random common left shifts confirm that the shifted and reduced encodings agree, and random stretch runs use ratios with 2n ≤ m.

// File: rtl/modfrac_clkdiv.sv
module modfrac_clkdiv #(
  parameter bit WIDE = 1'b0,
  parameter int FW   = WIDE ? 13 : 8,
  parameter int CW   = 3 + 2 * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic          tick_o,
  output logic          div_o,
  output logic [FW-1:0] n_rb_o,
  output logic [FW:0]   m_rb_o
);
  localparam int ADD_LSB = 3;
  localparam int SUB_LSB = ADD_LSB + FW;
  localparam int AW      = FW + 2;
  localparam int TZW     = $clog2(FW);

  logic [CW-1:0]        ctrl_q;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] diff;
  logic signed [AW-1:0] acc_d;
  logic                 st_q;
  logic [FW-1:0]        madd, msub;
  logic [FW:0]          n_full, m_full;
  logic                 take_sub, half_ok, live;
  logic [TZW-1:0]       tz;

  assign madd   = ctrl_q[ADD_LSB +: FW];
  assign msub   = ctrl_q[SUB_LSB +: FW];
  assign n_full = (msub == '0) ? '0 : ({1'b0, ~msub} + 1'b1);
  assign m_full = {1'b0, madd} + n_full;
  assign live   = ctrl_q[0] & ~ctrl_q[1] & (|n_full);

  assign diff     = acc_q - $signed({1'b0, n_full});
  assign take_sub = ~diff[AW-1];
  assign acc_d    = take_sub ? diff : acc_q + $signed({2'b00, madd});
  assign half_ok  = {acc_d, 1'b0} >= {2'b00, m_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      acc_q  <= '0;
      tick_o <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      if (ctrl_q[1]) begin
        acc_q  <= '0;
        tick_o <= 1'b0;
        st_q   <= 1'b0;
      end else if (live) begin
        acc_q  <= acc_d;
        tick_o <= ~take_sub;
        st_q   <= ~take_sub | (st_q & half_ok);
      end else begin
        tick_o <= 1'b0;
        st_q   <= 1'b0;
      end
    end
  end

  assign div_o = ctrl_q[2] ? st_q : tick_o;

  always_comb begin
    tz = '0;
    for (int i = FW - 1; i >= 0; i--)
      if (madd[i] | msub[i]) tz = TZW'(i);
  end

  assign n_rb_o = FW'(n_full >> tz);
  assign m_rb_o = (|n_full) ? (m_full >> tz) : '0;
endmodule

// File: rtl/modfrac_clkdiv_chk.sv
module modfrac_clkdiv_chk #(
  parameter int FW = 8,
  parameter int CW = 3 + 2 * FW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ctrl_q,
  input logic [FW+1:0] acc_q,
  input logic          tick_o,
  input logic          div_o
);
  localparam int SUB_LSB = 3 + FW;

  assert_acc_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q[FW+1]);

  assert_zero_sub_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[SUB_LSB +: FW] == '0) |=> !tick_o);

  assert_unity_every_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !ctrl_q[1] && ctrl_q[3 +: FW] == '0 && ctrl_q[SUB_LSB +: FW] != '0)
      |=> tick_o);

  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> !tick_o);

  assert_halt_holds_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !ctrl_q[1]) |=> $stable(acc_q));

  assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |=> (!tick_o && !div_o && acc_q == '0));
endmodule

bind modfrac_clkdiv modfrac_clkdiv_chk #(.FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .acc_q(acc_q),
  .tick_o(tick_o), .div_o(div_o)
);

// File: tb/modfrac_clkdiv_bench.sv
`timescale 1ns/1ps
module modfrac_clkdiv_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wr_n = 1'b0, wr_w = 1'b0;
  logic [18:0] data_n = '0;
  logic [28:0] data_w = '0;
  logic tick_n, div_n, tick_w, div_w;
  logic [7:0]  nrb_n;
  logic [8:0]  mrb_n;
  logic [12:0] nrb_w;
  logic [13:0] mrb_w;

  modfrac_clkdiv #(.WIDE(1'b0)) u_modfrac_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_n), .wr_data(data_n),
    .tick_o(tick_n), .div_o(div_n), .n_rb_o(nrb_n), .m_rb_o(mrb_n));

  modfrac_clkdiv #(.WIDE(1'b1)) u_modfrac_clkdiv_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_w), .wr_data(data_w),
    .tick_o(tick_w), .div_o(div_w), .n_rb_o(nrb_w), .m_rb_o(mrb_w));

  int checks = 0, fails = 0;
  int pcnt, rcnt, bad_plain, bad_st, pcnt_w;
  bit prev_div = 1'b0, st_mode = 1'b0, done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    pcnt   += int'(tick_n);
    pcnt_w += int'(tick_w);
    if (div_n && !prev_div) rcnt++;
    prev_div = div_n;
    if (!st_mode && div_n != tick_n) bad_plain++;
    if (st_mode && tick_n && !div_n) bad_st++;
  endtask

  task automatic clear_cnt();
    pcnt = 0; rcnt = 0; bad_plain = 0; bad_st = 0; pcnt_w = 0;
  endtask

  task automatic wr8(logic [31:0] w);
    wr_n = 1'b1; data_n = w[18:0]; cyc(); wr_n = 1'b0;
  endtask

  task automatic wr13(logic [31:0] w);
    wr_w = 1'b1; data_w = w[28:0]; cyc(); wr_w = 1'b0;
  endtask

  function automatic logic [31:0] enc8(int n_e, int d_e, bit st, bit clr, bit run);
    int ng = -n_e;
    return {13'b0, ng[7:0], d_e[7:0], st, clr, run};
  endfunction

  function automatic logic [31:0] enc13(int n_e, int d_e, bit st, bit clr, bit run);
    int ng = -n_e;
    return {3'b0, ng[12:0], d_e[12:0], st, clr, run};
  endfunction

  function automatic int red_shift(int a, int b);
    int k = 0;
    if (a == 0) return 0;
    while (a % 2 == 0 && b % 2 == 0) begin a = a / 2; b = b / 2; k++; end
    return k;
  endfunction

  task automatic ratio_run(int n_e, int d_e, bit st, string tag);
    int k  = red_shift(n_e, d_e);
    int nr = n_e >> k;
    int mr = (n_e + d_e) >> k;
    st_mode = st;
    wr8(enc8(n_e, d_e, st, 1'b1, 1'b1));
    wr8(enc8(n_e, d_e, st, 1'b0, 1'b1));
    chk(nrb_n == 8'(nr), {tag, " R1/R10 n readback"}, int'(nrb_n), nr);
    chk(mrb_n == 9'(mr), {tag, " R10 m readback"}, int'(mrb_n), mr);
    clear_cnt();
    repeat (mr) cyc();
    chk(pcnt == nr, {tag, " R2/R3 pulses in first window"}, pcnt, nr);
    clear_cnt();
    repeat (mr) cyc();
    chk(pcnt == nr, {tag, " R2 pulses in second window"}, pcnt, nr);
    if (st) begin
      chk(rcnt == nr, {tag, " R9 stretched rises"}, rcnt, nr);
      chk(bad_st == 0, {tag, " R9 low during tick"}, bad_st, 0);
    end else begin
      chk(bad_plain == 0, {tag, " R8 div equals tick"}, bad_plain, 0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    clear_cnt();
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(!tick_n && !div_n, "R11 outputs low after reset", int'(tick_n | div_n), 0);
    chk(nrb_n == 0 && mrb_n == 0, "R11 readback zero after reset", int'(mrb_n), 0);

    ratio_run(3, 7, 1'b0, "3/10");
    ratio_run(3, 7, 1'b1, "3/10 stretch");
    ratio_run(12, 28, 1'b0, "3/10 shifted by 2");
    ratio_run(5, 250, 1'b1, "5/255 stretch");
    ratio_run(1, 0, 1'b0, "unity R5");
    ratio_run(128, 0, 1'b0, "unity shifted R5");
    wr8(enc8(7, 0, 1'b0, 1'b0, 1'b1));
    clear_cnt();
    repeat (6) cyc();
    chk(pcnt == 6, "R5 pulse on every active cycle", pcnt, 6);

    // R4: zero subtraction field, with and without addition value
    wr8(enc8(0, 5, 1'b0, 1'b0, 1'b1));
    clear_cnt();
    repeat (20) cyc();
    chk(pcnt == 0, "R4 no pulses with zero sub", pcnt, 0);
    chk(nrb_n == 0 && mrb_n == 0, "R4 readback zero", int'(mrb_n), 0);
    wr8(enc8(0, 0, 1'b0, 1'b0, 1'b1));
    clear_cnt();
    repeat (10) cyc();
    chk(pcnt == 0, "R4 no pulses with both zero", pcnt, 0);

    // R7: clear holds outputs low, first active cycle after release pulses
    st_mode = 1'b0;
    wr8(enc8(2, 3, 1'b0, 1'b0, 1'b1));
    repeat (7) cyc();
    wr8(enc8(2, 3, 1'b1, 1'b1, 1'b1));
    clear_cnt();
    repeat (5) cyc();
    chk(pcnt == 0 && !div_n, "R7 quiet while clear set", pcnt, 0);
    wr8(enc8(2, 3, 1'b0, 1'b0, 1'b1));
    chk(!tick_n, "R7 still quiet at release edge", int'(tick_n), 0);
    cyc();
    chk(tick_n, "R7 pulse on first cycle after release", int'(tick_n), 1);

    // R6: pause mid-stream, pulse count over active cycles only
    begin
      int held;
      wr8(enc8(3, 7, 1'b0, 1'b1, 1'b1));
      wr8(enc8(3, 7, 1'b0, 1'b0, 1'b1));
      clear_cnt();
      repeat (3) cyc();
      wr8(enc8(3, 7, 1'b0, 1'b0, 1'b0));
      held = pcnt;
      repeat (6) cyc();
      chk(pcnt == held, "R6 no pulses while run low", pcnt, held);
      wr8(enc8(3, 7, 1'b0, 1'b0, 1'b1));
      chk(pcnt == held, "R6 resume edge inactive", pcnt, held);
      repeat (6) cyc();
      chk(pcnt == 3, "R6 pulses over interrupted window", pcnt, 3);
    end

    // random ratios with random common left shifts
    for (int it = 0; it < 12; it++) begin
      int n    = 1 + int'($urandom % 127);
      int d    = int'($urandom % 128);
      int kmax = 0;
      int k;
      bit st;
      while ((n << (kmax + 1)) < 256 && (d << (kmax + 1)) < 256) kmax++;
      k  = int'($urandom % (kmax + 1));
      st = (2 * n <= n + d) ? bit'($urandom % 2) : 1'b0;
      ratio_run(n << k, d << k, st, "random R3");
    end

    // R12: wide variant
    wr13(enc13(1000, 5000, 1'b0, 1'b1, 1'b1));
    wr13(enc13(1000, 5000, 1'b0, 1'b0, 1'b1));
    chk(nrb_w == 13'd125 && mrb_w == 14'd750, "R12/R10 wide readback", int'(mrb_w), 750);
    clear_cnt();
    repeat (750) cyc();
    chk(pcnt_w == 125, "R12/R3 wide shifted 125/750", pcnt_w, 125);
    wr13(enc13(4095, 1, 1'b0, 1'b1, 1'b1));
    wr13(enc13(4095, 1, 1'b0, 1'b0, 1'b1));
    chk(nrb_w == 13'd4095 && mrb_w == 14'd4096, "R12 wide readback odd", int'(mrb_w), 4096);
    clear_cnt();
    repeat (4096) cyc();
    chk(pcnt_w == 4095, "R12/R2 wide 4095/4096", pcnt_w, 4095);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule